// File: doc/BRIEF.md
# Prime-Modulus Halfword Checksum Engine

This block computes a 32-bit position-weighted checksum over a stream of 16-bit halfwords. It takes one halfword per cycle over a valid/ready handshake and keeps two running sums modulo the prime 65521. The first sum adds each halfword. The second sum adds the updated first sum on every beat, so the result depends on where each halfword sits in the block.

Reducing modulo a prime instead of 2^16-1 makes 0xFFFF and 0x0000 contribute differently. The result bits are also spread evenly. The cost is that an input v and an input v+65521 (v from 0 to 14) alias to the same contribution. This is accepted behaviour.

A block opens with a start pulse, which clears both sums and any held result. The halfword marked last closes the block. One cycle later the packed result is registered and flagged valid. It stays unchanged until the next start pulse.

Top module: `prime_fletcher16`

## Requirements
- R1: A beat is accepted when `in_valid_i` and `in_ready_o` are high and `start_i` is low. Each accepted beat adds its halfword into the first sum, modulo 65521.
- R2: Both sums are always below 65521 and are kept modulo 65521. A first-sum update up to 131055 is fully reduced, for example 65520 followed by 0xFFFF gives 13.
- R3: On every accepted beat the second sum adds the already-updated first sum, modulo 65521.
- R4: 0xFFFF and 0x0000 give different checksums. A halfword v+65521 gives the same checksum as v; for example 0xFFFF and 0x000E both give 0x000E000E.
- R5: Swapping two unequal halfwords in a block changes the checksum; {1,2} gives 0x00040003 and {2,1} gives 0x00050003.
- R6: A start pulse clears both sums, `res_valid_o` and `res_data_o` at the next edge. A beat presented in the same cycle as the start pulse is ignored.
- R7: While `in_valid_i` is low, both sums hold their values, so idle gaps inside a block do not change the checksum.
- R8: In the cycle after an accepted last beat, `in_ready_o` is low. In the cycle after that, `res_valid_o` is high and `in_ready_o` is high again. Outside the finishing cycle, `in_ready_o` is high.
- R9: `res_data_o` holds the second sum in bits 31:16 and the first sum in bits 15:0. It stays unchanged and valid until the next start pulse, even if further beats arrive.
- R10: After reset, `res_valid_o` is 0, `res_data_o` is 0 and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Clears sums and result for a new block |
| in_valid_i | input | 1 | Input halfword valid |
| in_ready_o | output | 1 | Engine can accept a halfword |
| in_data_i | input | 16 | Input halfword |
| in_last_i | input | 1 | Marks the final halfword of a block |
| res_valid_o | output | 1 | Result valid, held until next start |
| res_data_o | output | 32 | {second sum, first sum} |

## Verification
The bench targets the reduction corners: a first-sum update that needs two subtractions, inputs at 0xFFF0 and above, and the aliasing pair 0xFFFF/0x000E. A design that subtracted only once would leave a sum at or above 65521. A design using ones'-complement folding would map 0xFFFF to zero. The bench also swaps halfword order to expose a second sum that ignores position. It inserts idle gaps, sends a beat alongside the start pulse, and sends beats after a result is out. These catch a design that counts stalled beats, a start that does not take priority, and a result that gets overwritten before the next start. A 1000-halfword block is compared with a running model in the bench.

// File: rtl/fl_pkg.sv
package fl_pkg;
  localparam int unsigned FL_DATA_W = 16;
  localparam int unsigned FL_MOD    = 65521;
endpackage

// File: rtl/fl_mod_add.sv
// Adds two residues and reduces the sum with up to NSUB conditional subtractions.
module fl_mod_add #(
  parameter int unsigned W    = fl_pkg::FL_DATA_W,
  parameter int unsigned MOD  = fl_pkg::FL_MOD,
  parameter int unsigned NSUB = 1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  localparam int unsigned EW = W + 2;
  localparam logic [EW-1:0] MOD_E = EW'(MOD);

  logic [EW-1:0] stage [NSUB+1];

  assign stage[0] = {2'b00, a_i} + {2'b00, b_i};

  for (genvar i = 0; i < NSUB; i++) begin : g_sub
    assign stage[i+1] = (stage[i] >= MOD_E) ? stage[i] - MOD_E : stage[i];
  end

  assign y_o = stage[NSUB][W-1:0];
endmodule

// File: rtl/fl_sum_core.sv
module fl_sum_core #(
  parameter int unsigned W   = fl_pkg::FL_DATA_W,
  parameter int unsigned MOD = fl_pkg::FL_MOD
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         beat_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] sum_a_o,
  output logic [W-1:0] sum_b_o
);
  localparam int unsigned EW = W + 2;
  localparam logic [EW-1:0] MOD_E = EW'(MOD);
  // first-sum update reaches 2*2^W-1-15, needs two subtractions
  localparam int unsigned A_SUB = 2;
  localparam int unsigned B_SUB = 1;

  logic [W-1:0] sum_a_q, sum_b_q, sum_a_d, sum_b_d;

  fl_mod_add #(.W(W), .MOD(MOD), .NSUB(A_SUB)) u_add_a (
    .a_i(sum_a_q), .b_i(data_i), .y_o(sum_a_d)
  );

  fl_mod_add #(.W(W), .MOD(MOD), .NSUB(B_SUB)) u_add_b (
    .a_i(sum_b_q), .b_i(sum_a_d), .y_o(sum_b_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_a_q <= '0;
      sum_b_q <= '0;
    end else if (clr_i) begin
      sum_a_q <= '0;
      sum_b_q <= '0;
    end else if (beat_i) begin
      sum_a_q <= sum_a_d;
      sum_b_q <= sum_b_d;
    end
  end

  assign sum_a_o = sum_a_q;
  assign sum_b_o = sum_b_q;

  assert_sum_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({2'b00, sum_a_q} < MOD_E) && ({2'b00, sum_b_q} < MOD_E));

  assert_a_update_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i && !clr_i |=>
      {2'b00, sum_a_q} == ({2'b00, $past(sum_a_q)} + {2'b00, $past(data_i)}) % MOD_E);

  assert_b_update_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i && !clr_i |=>
      {2'b00, sum_b_q} == ({2'b00, $past(sum_b_q)} + {2'b00, sum_a_q}) % MOD_E);

  assert_sum_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sum_a_q == '0) && (sum_b_q == '0));

  assert_sum_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beat_i && !clr_i |=> $stable(sum_a_q) && $stable(sum_b_q));
endmodule

// File: rtl/fl_result_reg.sv
module fl_result_reg #(
  parameter int unsigned W = fl_pkg::FL_DATA_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           beat_i,
  input  logic           last_i,
  input  logic [W-1:0]   sum_a_i,
  input  logic [W-1:0]   sum_b_i,
  output logic           ready_o,
  output logic           res_valid_o,
  output logic [2*W-1:0] res_data_o
);
  logic           fin_q;
  logic           res_valid_q;
  logic [2*W-1:0] res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fin_q       <= 1'b0;
      res_valid_q <= 1'b0;
      res_q       <= '0;
    end else if (clr_i) begin
      fin_q       <= 1'b0;
      res_valid_q <= 1'b0;
      res_q       <= '0;
    end else begin
      // a held result is frozen until the next clear
      fin_q <= beat_i && last_i && !res_valid_q;
      if (fin_q) begin
        res_valid_q <= 1'b1;
        res_q       <= {sum_b_i, sum_a_i};
      end
    end
  end

  assign ready_o     = !fin_q;
  assign res_valid_o = res_valid_q;
  assign res_data_o  = res_q;

  assert_ready_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i && last_i && !clr_i && !res_valid_o |=> !ready_o ##1 (res_valid_o && ready_o));

  assert_res_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !clr_i |=> res_valid_o && $stable(res_data_o));

  assert_res_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !res_valid_o && (res_data_o == '0));
endmodule

// File: rtl/prime_fletcher16.sv
module prime_fletcher16 #(
  parameter int unsigned DATA_W = fl_pkg::FL_DATA_W,
  parameter int unsigned MOD    = fl_pkg::FL_MOD
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [DATA_W-1:0]   in_data_i,
  input  logic                in_last_i,
  output logic                res_valid_o,
  output logic [2*DATA_W-1:0] res_data_o
);
  logic              beat;
  logic [DATA_W-1:0] sum_a, sum_b;

  // start has priority over a concurrent beat
  assign beat = in_valid_i && in_ready_o && !start_i;

  fl_sum_core #(.W(DATA_W), .MOD(MOD)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_i),
    .beat_i  (beat),
    .data_i  (in_data_i),
    .sum_a_o (sum_a),
    .sum_b_o (sum_b)
  );

  fl_result_reg #(.W(DATA_W)) u_res (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (start_i),
    .beat_i      (beat),
    .last_i      (in_last_i),
    .sum_a_i     (sum_a),
    .sum_b_i     (sum_b),
    .ready_o     (in_ready_o),
    .res_valid_o (res_valid_o),
    .res_data_o  (res_data_o)
  );

  assert_reset_state_R10: assert property (@(posedge clk_i)
    !rst_ni |=> !res_valid_o && in_ready_o);
endmodule

// File: tb/sim_prime_fletcher16.sv
module sim_prime_fletcher16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        res_valid;
  logic [31:0] res_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prime_fletcher16 u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_last_i(in_last), .res_valid_o(res_valid), .res_data_o(res_data)
  );

  localparam int NV = 8;
  localparam logic [15:0] VEC_W [NV][4] = '{
    '{16'h0001, 16'h0002, 16'h0000, 16'h0000},
    '{16'h0002, 16'h0001, 16'h0000, 16'h0000},
    '{16'hFFFF, 16'h0000, 16'h0000, 16'h0000},
    '{16'h0000, 16'h0000, 16'h0000, 16'h0000},
    '{16'h000E, 16'h0000, 16'h0000, 16'h0000},
    '{16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000},
    '{16'hFFF0, 16'hFFF0, 16'h0000, 16'h0000},
    '{16'hFFF0, 16'hFFFF, 16'h0000, 16'h0000}
  };
  localparam int VEC_N [NV] = '{2, 2, 1, 1, 1, 2, 2, 2};
  localparam logic [31:0] VEC_X [NV] = '{
    32'h0004_0003, 32'h0005_0003, 32'h000E_000E, 32'h0000_0000,
    32'h000E_000E, 32'h002A_001C, 32'hFFEE_FFEF, 32'h000C_000D
  };
  localparam string VEC_T [NV] = '{"R5", "R5", "R4", "R4", "R4", "R3", "R2", "R2"};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic beat(input logic [15:0] d, input logic l, input int gap);
    repeat (gap) @(negedge clk);
    @(negedge clk); in_valid = 1'b1; in_data = d; in_last = l;
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  // called right after the last beat's edge
  task automatic expect_result(input string tag, input logic [31:0] exp);
    check("R8 ready low in finishing cycle", {31'b0, in_ready}, 32'd0);
    check("R8 valid not yet", {31'b0, res_valid}, 32'd0);
    @(posedge clk); #1;
    check("R8 result valid", {31'b0, res_valid}, 32'd1);
    check("R8 ready back", {31'b0, in_ready}, 32'd1);
    check(tag, res_data, exp);
  endtask

  function automatic logic [31:0] model_step(input logic [31:0] ab, input logic [15:0] d);
    int a, b;
    a = (int'(ab[15:0]) + int'(d)) % 65521;
    b = (int'(ab[31:16]) + a) % 65521;
    return {b[15:0], a[15:0]};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] m;
    // R10 reset state
    repeat (3) @(negedge clk);
    check("R10 valid", {31'b0, res_valid}, 32'd0);
    check("R10 ready", {31'b0, in_ready}, 32'd1);
    check("R10 data", res_data, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      pulse_start();
      m = '0;
      for (int k = 0; k < VEC_N[i]; k++) begin
        beat(VEC_W[i][k], k == VEC_N[i] - 1, 0);
        m = model_step(m, VEC_W[i][k]);
      end
      expect_result({VEC_T[i], " vector"}, VEC_X[i]);
      check({VEC_T[i], " model R1"}, m, VEC_X[i]);
    end

    // R7 idle gaps inside a block
    pulse_start();
    beat(16'h0001, 1'b0, 3);
    beat(16'h0002, 1'b1, 5);
    expect_result("R7 gaps", 32'h0004_0003);

    // R9 hold under later beats, then R6 clear
    beat(16'h1234, 1'b1, 0);
    check("R9 ready stays high", {31'b0, in_ready}, 32'd1);
    repeat (3) @(negedge clk);
    check("R9 held", res_data, 32'h0004_0003);
    check("R9 valid held", {31'b0, res_valid}, 32'd1);
    pulse_start();
    check("R6 valid cleared", {31'b0, res_valid}, 32'd0);
    check("R6 data cleared", res_data, 32'd0);

    // R6 beat alongside start ignored
    @(negedge clk); start = 1'b1; in_valid = 1'b1; in_data = 16'h0005;
    @(negedge clk); start = 1'b0; in_valid = 1'b0;
    beat(16'h0001, 1'b0, 0);
    beat(16'h0002, 1'b1, 0);
    expect_result("R6 start priority", 32'h0004_0003);

    // R2 long block against model
    pulse_start();
    m = '0;
    for (int k = 0; k < 1000; k++) begin
      logic [15:0] d;
      d = 16'((k * 40503 + 7) ^ (k << 9));
      beat(d, k == 999, 0);
      m = model_step(m, d);
    end
    expect_result("R2 long block", m);

    finish_run();
  end
endmodule